// File: doc/BRIEF.md
# Bus-Attached SPI Master with Placeholder Register Window

This block hangs off a simple single-master register bus and drives a four-wire SPI link as its master. Software sees a 1 KiB window that holds two free-form control words, a status word, a data word and five fixed placeholder words kept for register-map compatibility. The only register with a side effect is the data word. Writing it sends the low byte of the written value. Reading it sends the byte currently held and returns the byte that comes back. Either way, the received byte replaces the data word.

A data-word access stalls the bus. `bus_ready` stays low until the byte has been shifted out and in, so software never has to poll for completion. A receive-not-empty flag is set by a completed write exchange and is cleared by the read that returns a received byte. The link runs in mode 0: the clock idles low, data is sampled on the rising edge and shifted on the falling edge, the most significant bit goes first, and chip select stays low for the whole byte.

Top module: `sbus_spi_master`

## Requirements
- R1: After reset the window reads as follows: control word 0 (offset 0x00) and control word 1 (0x04) are 0, status (0x08) is 0x0000000A, data (0x0C) is 0x0000000C, offset 0x10 is 0x00000007, offsets 0x14, 0x18 and 0x1C are 0, and offset 0x20 is 0x00000002.
- R2: Control words 0 and 1 store all 32 written bits and read back the last value written.
- R3: The status word ignores writes. Status bits that could change keep their value across a write to offset 0x08.
- R4: The five placeholder words at 0x10, 0x14, 0x18, 0x1C and 0x20 discard writes and always read their reset values.
- R5: Every offset from 0x24 up to 0x3FC reads 0, and writes to these offsets change no register.
- R6: A write to offset 0x0C shifts out bits [7:0] of the write data, most significant bit first. When the byte is done, the data word holds the received byte zero-extended, and status bit 0 (receive-not-empty) is 1.
- R7: A read of offset 0x0C first shifts out bits [7:0] of the current data word. It then returns the received byte zero-extended, and status bit 0 is 0 after the read.
- R8: During a data-word access `bus_ready` is low until the exchange completes. Accesses to any other offset complete in the cycle they are presented, with `bus_ready` high.
- R9: Status bit 7 is 1 while a byte is shifting. Status bit 1 is its inverse. Status bit 3 is always 1, and all other status bits are 0.
- R10: Each exchange makes exactly 8 rising clock edges while chip select is low. The SPI clock is low whenever chip select is high, and its period is 2*DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (10) | Byte offset inside the window; bits [1:0] ignored |
| bus_wr | input | 1 | Write request, held until `bus_ready` is sampled high |
| bus_rd | input | 1 | Read request, held until `bus_ready` is sampled high |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle `bus_ready` is high |
| bus_ready | output | 1 | Access completes at the clock edge where this is high |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
On every cycle the assertions check the following:
- the SPI clock can be high only while chip select is low;
- a data-word access stays stalled while the engine is busy, and every other access is never stalled;
- status reads always show the busy and transmit-empty bits as complements, with bit 3 set;
- the receive flag is set right after a completed data write and cleared right after a completed data read.

Other behaviours only the bench scenarios can show. These are the bit order on the wire, the exact received value through a shift-register slave, and the discarded writes to the placeholder, status and unmapped offsets. The bench sweeps all 256 transmit byte values.

// File: rtl/spim_pkg.sv
// Package: shared constants and state types for the SPI master block.
// Assumes a 32-bit data bus with word-aligned register offsets.
package spim_pkg;
    // Word index (byte offset / 4) of each register in the window
    localparam int IDX_CTL0  = 0;
    localparam int IDX_CTL1  = 1;
    localparam int IDX_STAT  = 2;
    localparam int IDX_DATA  = 3;
    localparam int IDX_PH0   = 4;
    localparam int IDX_PH1   = 5;
    localparam int IDX_PH2   = 6;
    localparam int IDX_PH3   = 7;
    localparam int IDX_PH4   = 8;

    // Fixed contents of the placeholder words and data reset value
    localparam logic [31:0] PH0_VAL   = 32'h0000_0007;
    localparam logic [31:0] PH1_VAL   = 32'h0000_0000;
    localparam logic [31:0] PH2_VAL   = 32'h0000_0000;
    localparam logic [31:0] PH3_VAL   = 32'h0000_0000;
    localparam logic [31:0] PH4_VAL   = 32'h0000_0002;
    localparam logic [31:0] DATA_RST  = 32'h0000_000C;

    // Status bit positions
    localparam int ST_RXNE = 0;
    localparam int ST_TXE  = 1;
    localparam int ST_FIX  = 3;
    localparam int ST_BUSY = 7;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_XFER,
        BS_DONE
    } bus_st_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_FIN
    } sh_st_t;
endpackage

// File: rtl/spim_tick.sv
// Module: spim_tick
// Emits a one-cycle tick every DIV clocks while enabled, marking each
// SPI clock half-period. Restarts from zero whenever the enable drops.
module spim_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    // Count system clocks within one half-period of the SPI clock
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spim_shifter.sv
// Module: spim_shifter
// Mode-0 SPI shift engine for one FRAME_W-bit frame, MSB first. It
// samples MISO on the rising edge and shifts on the falling edge. Chip
// select stays low one cycle past the last falling edge. `start` is
// honoured only while idle. `done` pulses once, with `rx` valid from
// that cycle until the next start.
module spim_shifter
    import spim_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int DIV     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] rx
);
    localparam int BCW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

    sh_st_t             st;
    logic [FRAME_W-1:0] sh;
    logic [BCW-1:0]     bit_cnt;
    logic               samp;
    logic               tick;

    assign busy = (st != SH_IDLE);
    assign mosi = sh[FRAME_W-1];
    assign rx   = sh;

    spim_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .tick  (tick)
    );

    // Frame sequencer: load, toggle the clock on ticks, shift, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SH_IDLE;
            sh      <= '0;
            bit_cnt <= '0;
            samp    <= 1'b0;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: begin
                    if (start) begin
                        sh      <= tx;
                        bit_cnt <= '0;
                        cs_n    <= 1'b0;
                        st      <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (tick) begin
                        sclk <= 1'b1;
                        samp <= miso;
                        st   <= SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        sh   <= {sh[FRAME_W-2:0], samp};
                        if (bit_cnt == BCW'(FRAME_W - 1)) begin
                            done <= 1'b1;
                            st   <= SH_FIN;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            st      <= SH_LOW;
                        end
                    end
                end
                default: begin
                    cs_n <= 1'b1;
                    st   <= SH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sbus_spi_master.sv
// Module: sbus_spi_master (top)
// Register window plus bus handshake around the shift engine. Assumes
// a single bus master that holds wr/rd, addr and wdata stable until it
// samples bus_ready high, then drops the request for at least one cycle.
module sbus_spi_master
    import spim_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int FRAME_W = 8,
    parameter int DIV     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam int IW = ADDR_W - 2;

    bus_st_t            bst;
    logic [DATA_W-1:0]  ctl0_q;
    logic [DATA_W-1:0]  ctl1_q;
    logic [DATA_W-1:0]  data_q;
    logic               rxne_q;
    logic               eng_busy;
    logic               eng_done;
    logic               eng_start;
    logic [FRAME_W-1:0] eng_tx;
    logic [FRAME_W-1:0] eng_rx;
    logic [IW-1:0]      widx;
    logic               acc;
    logic               data_hit;
    logic [DATA_W-1:0]  stat_w;

    assign widx     = bus_addr[ADDR_W-1:2];
    assign acc      = bus_wr || bus_rd;
    assign data_hit = (widx == IW'(IDX_DATA));

    // Data accesses wait for the exchange; everything else is zero-wait
    assign bus_ready = !(acc && data_hit) || (bst == BS_DONE);

    assign eng_start = (bst == BS_IDLE) && acc && data_hit;
    assign eng_tx    = bus_wr ? bus_wdata[FRAME_W-1:0] : data_q[FRAME_W-1:0];

    // Status word is assembled live from the engine and the receive flag
    always_comb begin
        stat_w          = '0;
        stat_w[ST_RXNE] = rxne_q;
        stat_w[ST_TXE]  = !eng_busy;
        stat_w[ST_FIX]  = 1'b1;
        stat_w[ST_BUSY] = eng_busy;
    end

    // Read multiplexer over the window; unmapped offsets read zero
    always_comb begin
        case (widx)
            IW'(IDX_CTL0): bus_rdata = ctl0_q;
            IW'(IDX_CTL1): bus_rdata = ctl1_q;
            IW'(IDX_STAT): bus_rdata = stat_w;
            IW'(IDX_DATA): bus_rdata = data_q;
            IW'(IDX_PH0):  bus_rdata = DATA_W'(PH0_VAL);
            IW'(IDX_PH1):  bus_rdata = DATA_W'(PH1_VAL);
            IW'(IDX_PH2):  bus_rdata = DATA_W'(PH2_VAL);
            IW'(IDX_PH3):  bus_rdata = DATA_W'(PH3_VAL);
            IW'(IDX_PH4):  bus_rdata = DATA_W'(PH4_VAL);
            default:       bus_rdata = '0;
        endcase
    end

    // Control words: plain storage written on zero-wait bus writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0_q <= '0;
            ctl1_q <= '0;
        end else if (bus_wr) begin
            if (widx == IW'(IDX_CTL0)) ctl0_q <= bus_wdata;
            if (widx == IW'(IDX_CTL1)) ctl1_q <= bus_wdata;
        end
    end

    // Data-access sequencer: launch, wait for the engine, complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst    <= BS_IDLE;
            data_q <= DATA_W'(DATA_RST);
            rxne_q <= 1'b0;
        end else begin
            case (bst)
                BS_IDLE: begin
                    if (eng_start) begin
                        if (bus_wr) data_q <= bus_wdata;
                        bst <= BS_XFER;
                    end
                end
                BS_XFER: begin
                    if (eng_done) begin
                        data_q <= DATA_W'(eng_rx);
                        rxne_q <= 1'b1;
                        bst    <= BS_DONE;
                    end
                end
                default: begin
                    if (bus_rd) rxne_q <= 1'b0;
                    bst <= BS_IDLE;
                end
            endcase
        end
    end

    spim_shifter #(.FRAME_W(FRAME_W), .DIV(DIV)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .tx    (eng_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n),
        .busy  (eng_busy),
        .done  (eng_done),
        .rx    (eng_rx)
    );
endmodule

// File: rtl/spim_chk.sv
// Module: spim_chk
// Protocol and status checker bound to sbus_spi_master. It observes the
// bus ports, the SPI ports, the engine busy line and the receive flag.
module spim_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready,
    input logic              spi_sclk,
    input logic              spi_cs_n,
    input logic              busy,
    input logic              rxne
);
    logic at_data, at_stat, at_ph0, acc;
    assign at_data = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
    assign at_stat = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
    assign at_ph0  = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4));
    assign acc     = bus_wr || bus_rd;

    // R8
    dr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && at_data && busy) |-> !bus_ready);

    // R8
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !at_data) |-> bus_ready);

    // R10
    sclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);

    // R9
    stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_stat) |-> ((bus_rdata[1] == !bus_rdata[7]) && bus_rdata[3]));

    // R4
    ph_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_ph0) |-> (bus_rdata == DATA_W'(7)));

    // R6
    rxne_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_data && bus_ready) |=> rxne);

    // R7
    rxne_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_data && bus_ready) |=> !rxne);

    // R3
    stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_stat) |=> $stable(rxne));
endmodule

bind sbus_spi_master spim_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .busy      (eng_busy),
    .rxne      (rxne_q)
);

// File: tb/sim_sbus_spi_master.sv
// Bench for sbus_spi_master. The slave is an 8-bit shift register
// preset to 0xA5, so each exchange returns the byte sent before it.
module sim_sbus_spi_master;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sbus_spi_master #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // Shift-register slave: capture on rise, shift on fall
    logic [7:0] slv = 8'hA5;
    logic       slv_cap = 1'b0;
    assign spi_miso = slv[7];
    always @(posedge spi_sclk) if (!spi_cs_n) slv_cap = spi_mosi;
    always @(negedge spi_sclk) if (!spi_cs_n) slv = {slv[6:0], slv_cap};

    // Wire monitor: collects MOSI bits and counts rising edges per frame
    logic [7:0] mon_byte = '0;
    int         mon_rise = 0;
    always @(negedge spi_cs_n) mon_rise = 0;
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            mon_byte = {mon_byte[6:0], spi_mosi};
            mon_rise++;
        end
    end

    int stall;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [9:0] a, input logic [31:0] d,
                          output logic [31:0] q);
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = !wr; bus_wdata = d;
        stall = 0;
        #1;
        while (!bus_ready) begin
            @(negedge clk); #1;
            stall++;
        end
        q = bus_rdata;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        access(1'b1, a, d, dummy);
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] q);
        access(1'b0, a, 32'h0, q);
    endtask

    logic [31:0] q;
    logic [7:0]  model;
    logic [31:0] exp_dr;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values across the whole register set
        rd(10'h000, q); check("R1 ctl0", q, 32'h0);
        rd(10'h004, q); check("R1 ctl1", q, 32'h0);
        rd(10'h008, q); check("R1 stat", q, 32'h0000000A);
        rd(10'h010, q); check("R1 ph0", q, 32'h7);
        rd(10'h014, q); check("R1 ph1", q, 32'h0);
        rd(10'h018, q); check("R1 ph2", q, 32'h0);
        rd(10'h01C, q); check("R1 ph3", q, 32'h0);
        rd(10'h020, q); check("R1 ph4", q, 32'h2);
        check("R10 idle cs", {31'b0, spi_cs_n}, 32'h1);
        check("R10 idle sclk", {31'b0, spi_sclk}, 32'h0);

        // R2: walking ones and their complements through both control words
        for (int b = 0; b < 32; b++) begin
            wr(10'h000, 32'h1 << b);
            wr(10'h004, ~(32'h1 << b));
            rd(10'h000, q); check("R2 ctl0", q, 32'h1 << b);
            rd(10'h004, q); check("R2 ctl1", q, ~(32'h1 << b));
            check("R8 zero wait", stall, 0);
        end

        // R4: placeholders discard writes
        for (int i = 4; i <= 8; i++) wr(10'(i * 4), 32'hFFFF_FFFF);
        rd(10'h010, q); check("R4 ph0", q, 32'h7);
        rd(10'h014, q); check("R4 ph1", q, 32'h0);
        rd(10'h018, q); check("R4 ph2", q, 32'h0);
        rd(10'h01C, q); check("R4 ph3", q, 32'h0);
        rd(10'h020, q); check("R4 ph4", q, 32'h2);

        // R5: unmapped offsets read zero and do not alias onto registers
        wr(10'h000, 32'h1234_5678);
        for (int a = 9; a < 256; a += 7) begin
            wr(10'(a * 4), 32'hDEAD_BEEF);
            rd(10'(a * 4), q); check("R5 unmapped", q, 32'h0);
        end
        rd(10'h3FC, q); check("R5 top", q, 32'h0);
        rd(10'h000, q); check("R5 ctl0 intact", q, 32'h1234_5678);
        rd(10'h00C, q);
        model = 8'hA5;

        // R7: first data read sends reset data 0x0C and receives slave preset
        check("R7 first rx", q, 32'h000000A5);
        check("R7 sent reset byte", {24'b0, mon_byte}, 32'h0C);
        model = 8'h0C;
        exp_dr = 32'hA5;
        check("R8 data stall", {31'b0, stall >= 16 * DIV}, 32'h1);
        rd(10'h008, q); check("R7 rxne clear", q, 32'h0000000A);

        // R3: status ignores writes
        wr(10'h008, 32'hFFFF_FFFF);
        rd(10'h008, q); check("R3 stat ro", q, 32'h0000000A);

        // R6 and R9, R10: sweep every transmit byte
        for (int v = 0; v < 256; v++) begin
            wr(10'h00C, 32'hABCD_EF00 | 32'(v));
            exp_dr = {24'b0, model};
            model  = 8'(v);
            check("R6 mosi byte", {24'b0, mon_byte}, 32'(v));
            check("R10 rise count", mon_rise, 8);
            rd(10'h008, q); check("R6 R9 stat", q, 32'h0000000B);
            if (v == 100) begin
                wr(10'h008, 32'h0);
                rd(10'h008, q); check("R3 rxne held", q, 32'h0000000B);
            end
            if ((v % 32) == 31) begin
                rd(10'h00C, q);
                check("R7 rx", q, {24'b0, model});
                check("R7 sent dr", {24'b0, mon_byte}, exp_dr);
                model  = exp_dr[7:0];
                exp_dr = 32'(v);
                rd(10'h008, q); check("R7 stat", q, 32'h0000000A);
            end
        end
        check("R10 end cs", {31'b0, spi_cs_n}, 32'h1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule